// File: doc/BRIEF.md
# Ternary Front-Panel Control Sequencer

This block turns the switches and lamps of a small balanced-ternary computer's front panel into control actions. A bank of nine three-position address switches and three data switches sets a value. Three three-position control switches act on the machine. The Stop/Go switch runs or pauses the processor core. The Interrupt/Return switch forces a jump to the switch address, or returns to the interrupted program. The Write/Read switch stores or fetches one memory cell by hand. Nine address lamps and three data lamps show the program counter and the cell under it. While a manual access is held, they show the cell being accessed instead.

The processor core and the memory are outside the block and are reached through plain request ports. The core reports its program counter on `cpu_pc`. It accepts a one-cycle `pc_load` with the new value. The memory returns a cell on `mem_rdata` combinationally for `mem_addr`, and it takes a one-cycle `mem_wr` strobe. Each control switch is synchronised and debounced. An action fires once, when the settled switch leaves neutral.

Top module: `tpanel_seq`

## Requirements
- R1: Each trit is two bits, with 00 = O, 01 = P and 10 = N. Each control switch is two bits, with 00 = neutral, 01 = up and 10 = down. After reset, `cpu_run`, `pc_load` and `mem_wr` are 0. With `cpu_pc` = 0 and `mem_rdata` = 0, every lamp shows O.
- R2: `cpu_run` is 1 while the settled Stop/Go switch is down, and 0 when it is neutral or up.
- R3: When Interrupt/Return moves from neutral to up, the block gives exactly one `pc_load` pulse, with `pc_load_val` equal to the address switches. The block keeps the `cpu_pc` value of that moment as the return address.
- R4: When Interrupt/Return moves from neutral to down, the block gives exactly one `pc_load` pulse carrying the stored return address. The store holds a single address, so a second interrupt replaces it.
- R5: In pause mode, when Write/Read moves from neutral to up, the block gives exactly one `mem_wr` pulse, with `mem_addr` equal to the address switches and `mem_wdata` equal to the data switches. While the switch stays up, the address lamps show that address and the data lamps show the written value.
- R6: In pause mode, when Write/Read moves from neutral to down, the address switches are captured. While the switch stays down, `mem_addr` and the address lamps carry that address, and the data lamps show `mem_rdata`.
- R7: With Write/Read neutral, `mem_addr` and the address lamps follow `cpu_pc`, and the data lamps follow `mem_rdata`.
- R8: In run mode, Write/Read moves are ignored. No `mem_wr` is issued, and the lamps keep the program-counter view.
- R9: Each action fires only once, on the move out of neutral. Holding a switch does not repeat the action. Moving straight from up to down, without passing through neutral, does nothing.
- R10: A change on a control switch that lasts fewer than `DB_CYCLES` clock cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_addr | input | 2*ADDR_TRITS | Address switch bank, one two-bit trit per switch |
| sw_data | input | 2*DATA_TRITS | Data switch bank |
| sw_run | input | 2 | Stop/Go switch |
| sw_irq | input | 2 | Interrupt/Return switch |
| sw_mem | input | 2 | Write/Read switch |
| cpu_pc | input | 2*ADDR_TRITS | Program counter of the core |
| cpu_run | output | 1 | Run enable to the core |
| pc_load | output | 1 | One-cycle program-counter load request |
| pc_load_val | output | 2*ADDR_TRITS | Value to load into the program counter |
| mem_addr | output | 2*ADDR_TRITS | Memory address for display, read and write |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_wdata | output | 2*DATA_TRITS | Memory write data |
| mem_rdata | input | 2*DATA_TRITS | Memory read data for `mem_addr` |
| lamp_addr | output | 2*ADDR_TRITS | Address indicators |
| lamp_data | output | 2*DATA_TRITS | Data indicators |

## Verification
The hardest cases to reach are the ones where a switch acts only in combination with another switch or with its own history. A write attempted while the core runs must be ignored. A return must carry a return address that a second interrupt has since overwritten. A move from up to down must not count as a fresh action. The stimulus reaches these by driving the switches in deliberate sequences, holding `cpu_pc` at a different value before each interrupt. It then mixes in seeded random operations, with random run state, addresses and data, checked against a bench model of the return-address store.

// File: rtl/tpanel_seq.sv
module tpanel_seq #(
  parameter int ADDR_TRITS = 9,
  parameter int DATA_TRITS = 3,
  parameter int DB_CYCLES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*ADDR_TRITS-1:0] sw_addr,
  input  logic [2*DATA_TRITS-1:0] sw_data,
  input  logic [1:0]              sw_run,
  input  logic [1:0]              sw_irq,
  input  logic [1:0]              sw_mem,
  input  logic [2*ADDR_TRITS-1:0] cpu_pc,
  output logic                    cpu_run,
  output logic                    pc_load,
  output logic [2*ADDR_TRITS-1:0] pc_load_val,
  output logic [2*ADDR_TRITS-1:0] mem_addr,
  output logic                    mem_wr,
  output logic [2*DATA_TRITS-1:0] mem_wdata,
  input  logic [2*DATA_TRITS-1:0] mem_rdata,
  output logic [2*ADDR_TRITS-1:0] lamp_addr,
  output logic [2*DATA_TRITS-1:0] lamp_data
);
  localparam int AW = 2*ADDR_TRITS;
  localparam int DW = 2*DATA_TRITS;
  localparam int CW = $clog2(DB_CYCLES+1);
  localparam logic [1:0] NEU = 2'b00, UP = 2'b01, DN = 2'b10;
  localparam logic [1:0] M_IDLE = 2'd0, M_WR = 2'd1, M_RD = 2'd2;

  logic [1:0] sw_in [3];
  logic [1:0] db [3];
  logic [1:0] pv [3];

  assign sw_in[0] = sw_run;
  assign sw_in[1] = sw_irq;
  assign sw_in[2] = sw_mem;

  for (genvar g = 0; g < 3; g++) begin : g_deb
    logic [1:0] s0, s1, cand, stab, prev;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s0 <= NEU; s1 <= NEU; cand <= NEU; stab <= NEU; prev <= NEU; cnt <= '0;
      end else begin
        s0   <= sw_in[g];
        s1   <= s0;
        prev <= stab;
        if (s1 != cand) begin
          cand <= s1;
          cnt  <= '0;
        end else if (cnt != CW'(DB_CYCLES-1)) begin
          cnt <= cnt + 1'b1;
        end else begin
          stab <= cand;
        end
      end
    end
    assign db[g] = stab;
    assign pv[g] = prev;
  end

  logic running;
  assign running = (db[0] == DN);
  assign cpu_run = running;

  logic ev_irq, ev_ret, ev_wr, ev_rd;
  assign ev_irq = (pv[1] == NEU) && (db[1] == UP);
  assign ev_ret = (pv[1] == NEU) && (db[1] == DN);
  assign ev_wr  = (pv[2] == NEU) && (db[2] == UP) && !running;
  assign ev_rd  = (pv[2] == NEU) && (db[2] == DN) && !running;

  logic [AW-1:0] saved_q, pcv_q, addr_q;
  logic [DW-1:0] wdat_q;
  logic [1:0]    mode_q;
  logic          load_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q <= '0; pcv_q <= '0; load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (ev_irq) begin
        load_q  <= 1'b1;
        pcv_q   <= sw_addr;
        saved_q <= cpu_pc;
      end else if (ev_ret) begin
        load_q <= 1'b1;
        pcv_q  <= saved_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE; addr_q <= '0; wdat_q <= '0; wr_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (ev_wr) begin
        mode_q <= M_WR;
        wr_q   <= 1'b1;
        addr_q <= sw_addr;
        wdat_q <= sw_data;
      end else if (ev_rd) begin
        mode_q <= M_RD;
        addr_q <= sw_addr;
      end else if (db[2] == NEU) begin
        mode_q <= M_IDLE;
      end
    end
  end

  assign pc_load     = load_q;
  assign pc_load_val = pcv_q;
  assign mem_wr      = wr_q;
  assign mem_wdata   = wdat_q;
  assign mem_addr    = (mode_q == M_IDLE) ? cpu_pc : addr_q;
  assign lamp_addr   = mem_addr;
  assign lamp_data   = (mode_q == M_WR) ? wdat_q : mem_rdata;
endmodule

// File: rtl/tpanel_seq_chk.sv
module tpanel_seq_chk #(
  parameter int AW = 18,
  parameter int DW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_run,
  input logic          pc_load,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] lamp_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] lamp_data
);
  // R8
  wr_only_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(!cpu_run));
  // R9
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R9
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  // R5
  wr_shows_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (lamp_data == mem_wdata && lamp_addr == mem_addr));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!pc_load && !mem_wr && !cpu_run));
endmodule

bind tpanel_seq tpanel_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_run(cpu_run), .pc_load(pc_load), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .lamp_addr(lamp_addr), .mem_wdata(mem_wdata), .lamp_data(lamp_data)
);

// File: tb/tpanel_seq_bench.sv
module tpanel_seq_bench;
  localparam int AT = 9, DT = 3, DB = 4;
  localparam int AW = 2*AT, DW = 2*DT;
  localparam logic [1:0] NEU = 2'b00, UP = 2'b01, DN = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] sw_addr = '0, cpu_pc = '0;
  logic [DW-1:0] sw_data = '0;
  logic [1:0] sw_run = NEU, sw_irq = NEU, sw_mem = NEU;
  logic cpu_run, pc_load, mem_wr;
  logic [AW-1:0] pc_load_val, mem_addr, lamp_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, lamp_data;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] fmem(input logic [AW-1:0] a);
    return a[5:0] ^ a[17:12];
  endfunction
  assign mem_rdata = fmem(mem_addr);

  tpanel_seq #(.ADDR_TRITS(AT), .DATA_TRITS(DT), .DB_CYCLES(DB)) u_tpanel_seq (
    .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_data(sw_data),
    .sw_run(sw_run), .sw_irq(sw_irq), .sw_mem(sw_mem), .cpu_pc(cpu_pc),
    .cpu_run(cpu_run), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .lamp_addr(lamp_addr), .lamp_data(lamp_data));

  int checks = 0, failures = 0;
  int n_load = 0, n_wr = 0;
  logic [AW-1:0] last_load, last_wa;
  logic [DW-1:0] last_wd;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n && pc_load) begin n_load++; last_load = pc_load_val; end
    if (rst_n && mem_wr)  begin n_wr++; last_wa = mem_addr; last_wd = mem_wdata; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (DB + 8) @(posedge clk);
    @(negedge clk);
  endtask

  logic [AW-1:0] saved_m;

  task automatic do_irq(input logic [AW-1:0] a, input logic [AW-1:0] pc);
    int n0;
    n0 = n_load; sw_addr = a; cpu_pc = pc;
    sw_irq = UP; settle();
    chk(n_load == n0 + 1, "R3 count", n_load - n0, 1);
    chk(last_load == a, "R3 value", last_load, a);
    saved_m = pc;
    sw_irq = NEU; settle();
  endtask

  task automatic do_ret();
    int n0;
    n0 = n_load;
    sw_irq = DN; settle();
    chk(n_load == n0 + 1, "R4 count", n_load - n0, 1);
    chk(last_load == saved_m, "R4 value", last_load, saved_m);
    sw_irq = NEU; settle();
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit run);
    int n0;
    n0 = n_wr; sw_addr = a; sw_data = d;
    sw_mem = UP; settle();
    if (run) begin
      chk(n_wr == n0, "R8 no write", n_wr - n0, 0);
      chk(lamp_addr == cpu_pc, "R8 lamp addr", lamp_addr, cpu_pc);
    end else begin
      chk(n_wr == n0 + 1, "R5 count", n_wr - n0, 1);
      chk(last_wa == a && last_wd == d, "R5 addr/data", {last_wa, last_wd}, {a, d});
      chk(lamp_data == d && lamp_addr == a, "R5 held lamps", {lamp_addr, lamp_data}, {a, d});
    end
    sw_mem = NEU; settle();
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input bit run);
    sw_addr = a; sw_mem = DN; settle();
    if (run) chk(lamp_addr == cpu_pc && lamp_data == fmem(cpu_pc), "R8 read ignored",
                 {lamp_addr, lamp_data}, {cpu_pc, fmem(cpu_pc)});
    else     chk(mem_addr == a && lamp_addr == a && lamp_data == fmem(a), "R6 read",
                 {lamp_addr, lamp_data}, {a, fmem(a)});
    sw_mem = NEU; settle();
  endtask

  initial begin
    int n0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!cpu_run && !pc_load && !mem_wr, "R1 reset ctrl", {cpu_run, pc_load, mem_wr}, 0);
    chk(lamp_addr == '0 && lamp_data == '0, "R1 reset lamps", {lamp_addr, lamp_data}, 0);

    // R2
    sw_run = DN; settle();
    chk(cpu_run == 1'b1, "R2 run", cpu_run, 1);
    cpu_pc = 18'h0_1245;
    do_wr(18'h2_0101, 6'h19, 1'b1);
    do_rd(18'h2_0101, 1'b1);
    sw_run = UP; settle();
    chk(cpu_run == 1'b0, "R2 up pauses", cpu_run, 0);
    sw_run = NEU; settle();
    chk(cpu_run == 1'b0, "R2 neutral pauses", cpu_run, 0);

    // R7
    cpu_pc = 18'h1_1111; @(negedge clk);
    chk(lamp_addr == cpu_pc && mem_addr == cpu_pc && lamp_data == fmem(cpu_pc), "R7 pc view",
        {lamp_addr, lamp_data}, {cpu_pc, fmem(cpu_pc)});

    do_irq(18'h1_0000, 18'h0_0024);
    do_irq(18'h0_0410, 18'h0_2888);  // R4 overwrite
    do_ret();
    do_wr(18'h2_1000, 6'h26, 1'b0);
    do_rd(18'h0_5555, 1'b0);

    // R9 hold and up-to-down
    n0 = n_load; sw_addr = 18'h0_0001;
    sw_irq = UP; settle(); settle();
    chk(n_load == n0 + 1, "R9 hold once", n_load - n0, 1);
    sw_irq = DN; settle();
    chk(n_load == n0 + 1, "R9 up->down none", n_load - n0, 1);
    sw_irq = NEU; settle();
    saved_m = cpu_pc;

    // R10 glitch
    n0 = n_load;
    sw_irq = UP; repeat (2) @(posedge clk); sw_irq = NEU; settle();
    chk(n_load == n0, "R10 glitch", n_load - n0, 0);

    for (int i = 0; i < 40; i++) begin
      bit run;
      run = $urandom_range(0, 1) == 1;
      sw_run = run ? DN : NEU;
      cpu_pc = AW'($urandom);
      settle();
      case ($urandom_range(0, 3))
        0: do_irq(AW'($urandom), AW'($urandom));
        1: do_ret();
        2: do_wr(AW'($urandom), DW'($urandom), run);
        default: do_rd(AW'($urandom), run);
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule